// File: doc/BRIEF.md
# Fuse Program and Read Access Guard

This block owns a small one-time-programmable fuse array of pages by rows by 32-bit words. It serves two kinds of request. A program request names one bit, by page, row and column, and asks for it to be set. A read request names a word, by page and row, and returns it. Before a program request takes effect, the block checks several conditions: a global enable, a software lock that stays set once raised, fixed lock fuses that guard certain row ranges on page 0, and one lock fuse that guards the syndrome area of page 2. The lock fuses are themselves bits of the same array.

A program request always yields a done pulse. When the request is refused, or when it cannot set the bit, an error pulse comes with it. A read request always yields a done pulse. The key rows of page 0 cannot be read: a read of one of them returns zero and raises an error pulse. At reset, two anchor bits on row 0 of every page are set, and every other bit is clear.

Top module: `fuse_guard`

## Requirements
- R1: A request address packs the page in bits 16:13, the row in bits 12:5 and the column in bits 4:0. A read uses only the page and row fields and ignores bits 4:0.
- R2: `pgm_done_o` is high in exactly the cycle after each cycle with `pgm_req_i` high. `rd_done_o` is high in exactly the cycle after each cycle with `rd_req_i` high. Error and read data are valid in that same cycle.
- R3: While `pgm_en_i` is 0, every program request is refused and leaves the array unchanged.
- R4: A cycle with `lock_set_i` high raises a sticky lock, which only reset clears. While the lock is set, programs to page 0 rows 44 to 51 are refused.
- R5: On page 0, programs are refused when the guarding fuse (page 0, row/column) is set. The guards are: row 4 by 4/31; rows 8-11 by 43/27; rows 12-19 by 43/11; rows 20-27 by 43/13; rows 28-35 by 43/15; row 37 by 43/28; rows 64-71 by 43/6; rows 72-79 by 43/7; rows 80-87 by 43/8.
- R6: On page 2, programs to bit positions from row 129 column 0 through row 255 column 27 are refused when page 0 row 43 column 16 is set. Every other page 2 bit, and every bit of page 1, has no lock.
- R7: An accepted program sets its bit to 1, and no later request clears it. A refused or failed program raises `pgm_err_o` together with `pgm_done_o`. `pgm_err_o` is low for a successful program.
- R8: A program to page 3 or above, or to a bit that is already 1, fails and raises `pgm_err_o`.
- R9: A read of page 0 rows 12 through 35 returns 0 and raises `rd_err_o`. Any other in-range read returns the stored word with `rd_err_o` low.
- R10: After reset, row 0 of every page reads 0x08000002, every other word reads 0, the sticky lock is clear, and all done and error outputs are 0.
- R11: A read of page 3 or above returns 0 and raises `rd_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pgm_en_i | input | 1 | Global program enable |
| lock_set_i | input | 1 | Raises the sticky lock on page 0 rows 44-51 |
| pgm_req_i | input | 1 | Program request, one per high cycle |
| pgm_addr_i | input | 17 | Program address {page, row, column} |
| rd_req_i | input | 1 | Read request, one per high cycle |
| rd_addr_i | input | 17 | Read address {page, row, ignored} |
| pgm_done_o | output | 1 | Program finished pulse |
| pgm_err_o | output | 1 | Program refused or failed pulse |
| rd_done_o | output | 1 | Read finished pulse |
| rd_err_o | output | 1 | Read refused pulse |
| rd_data_o | output | 32 | Read word, held until the next read |

## Verification
Every result arrives one register stage after its request. The done flags, the error flags and the read word all change at the rising edge that samples the request. A program is visible to any read issued one cycle or more after it. The bench changes inputs only on falling edges and holds each request high for exactly one cycle. It samples the outputs on the next falling edge, half a period after the edge that loads them. Expected results come from a reference model of the array and the lock rules, which the bench updates only after a program it predicts will succeed.

// File: rtl/fuse_guard_pkg.sv
package fuse_guard_pkg;
  localparam int PAGE_W = 4;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 5;
  localparam int ADDR_W = PAGE_W + ROW_W + COL_W;

  // control row on page 0 holding most lock fuses
  localparam logic [ROW_W-1:0] CTL_ROW    = 8'd43;
  localparam logic [COL_W-1:0] SYN_LK_COL = 5'd16;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } fuse_addr_t;

  typedef struct packed {
    logic              hit;
    logic [ROW_W-1:0]  lk_row;
    logic [COL_W-1:0]  lk_col;
  } lock_ref_t;
endpackage

// File: rtl/fuse_lock_map.sv
module fuse_lock_map
  import fuse_guard_pkg::*;
(
  input  logic [ROW_W-1:0] row_i,
  output lock_ref_t        ref_o
);
  function automatic logic in_rng(logic [ROW_W-1:0] r, int lo, int hi);
    return (int'(r) >= lo) && (int'(r) <= hi);
  endfunction

  always_comb begin
    ref_o = '{hit: 1'b0, lk_row: CTL_ROW, lk_col: '0};
    if (row_i == 8'd4)            ref_o = '{hit: 1'b1, lk_row: 8'd4,    lk_col: 5'd31};
    else if (in_rng(row_i, 8, 11))  ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd27};
    else if (in_rng(row_i, 12, 19)) ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd11};
    else if (in_rng(row_i, 20, 27)) ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd13};
    else if (in_rng(row_i, 28, 35)) ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd15};
    else if (row_i == 8'd37)       ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd28};
    else if (in_rng(row_i, 64, 71)) ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd6};
    else if (in_rng(row_i, 72, 79)) ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd7};
    else if (in_rng(row_i, 80, 87)) ref_o = '{hit: 1'b1, lk_row: CTL_ROW, lk_col: 5'd8};
  end
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_guard_pkg::*;
#(
  parameter int PAGES = 3,
  parameter int ROWS  = 256,
  parameter int COLS  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  logic [PAGE_W-1:0] set_page_i,
  input  logic [ROW_W-1:0]  set_row_i,
  input  logic [COL_W-1:0]  set_col_i,
  input  logic [ROW_W-1:0]  tgt_row_i,
  input  logic [PAGE_W-1:0] tgt_page_i,
  output logic [COLS-1:0]   tgt_word_o,
  input  logic [PAGE_W-1:0] rd_page_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [COLS-1:0]   rd_word_o,
  input  logic [ROW_W-1:0]  lk_row_i,
  output logic [COLS-1:0]   lk_word_o,
  output logic [COLS-1:0]   ctl_word_o
);
  localparam int PG_IW = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int RW_IW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [PAGE_W-1:0] PAGES_L = PAGE_W'(PAGES);
  localparam logic [COLS-1:0] ANCHOR = (COLS'(1) << 27) | (COLS'(1) << 1);

  logic [COLS-1:0] mem_q [PAGES][ROWS];

  function automatic logic [PG_IW-1:0] pg_idx(logic [PAGE_W-1:0] p);
    return (p < PAGES_L) ? p[PG_IW-1:0] : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PAGES; p++)
        for (int r = 0; r < ROWS; r++)
          mem_q[p][r] <= (r == 0) ? ANCHOR : '0;
    end else if (set_en_i && (set_page_i < PAGES_L)) begin
      mem_q[pg_idx(set_page_i)][set_row_i[RW_IW-1:0]][set_col_i] <= 1'b1;
    end
  end

  assign tgt_word_o = (tgt_page_i < PAGES_L) ? mem_q[pg_idx(tgt_page_i)][tgt_row_i[RW_IW-1:0]] : '0;
  assign rd_word_o  = (rd_page_i < PAGES_L)  ? mem_q[pg_idx(rd_page_i)][rd_row_i[RW_IW-1:0]]   : '0;
  assign lk_word_o  = mem_q[0][lk_row_i[RW_IW-1:0]];
  assign ctl_word_o = mem_q[0][CTL_ROW[RW_IW-1:0]];
endmodule

// File: rtl/fuse_prog_check.sv
module fuse_prog_check
  import fuse_guard_pkg::*;
#(
  parameter int PAGES = 3,
  parameter int COLS  = 32
) (
  input  logic            pgm_en_i,
  input  logic            sticky_i,
  input  fuse_addr_t      addr_i,
  input  lock_ref_t       lref_i,
  input  logic [COLS-1:0] tgt_word_i,
  input  logic [COLS-1:0] lk_word_i,
  input  logic [COLS-1:0] ctl_word_i,
  output logic            refuse_o
);
  localparam logic [PAGE_W-1:0] PAGES_L = PAGE_W'(PAGES);
  localparam logic [ROW_W+COL_W-1:0] SYN_LO = {8'd129, 5'd0};
  localparam logic [ROW_W+COL_W-1:0] SYN_HI = {8'd255, 5'd27};

  logic page_bad, already, soft_hit, row_hit, syn_hit, lock_hit;
  logic [ROW_W+COL_W-1:0] bit_pos;

  assign bit_pos  = {addr_i.row, addr_i.col};
  assign page_bad = addr_i.page >= PAGES_L;
  assign already  = tgt_word_i[addr_i.col];
  assign soft_hit = sticky_i && (addr_i.row >= 8'd44) && (addr_i.row <= 8'd51);
  assign row_hit  = lref_i.hit && lk_word_i[lref_i.lk_col];
  assign syn_hit  = (bit_pos >= SYN_LO) && (bit_pos <= SYN_HI) && ctl_word_i[SYN_LK_COL];

  always_comb begin
    unique case (addr_i.page)
      4'd0:    lock_hit = soft_hit || row_hit;
      4'd2:    lock_hit = syn_hit;
      default: lock_hit = 1'b0;
    endcase
  end

  assign refuse_o = !pgm_en_i || page_bad || lock_hit || already;
endmodule

// File: rtl/fuse_guard.sv
module fuse_guard
  import fuse_guard_pkg::*;
#(
  parameter int PAGES = 3,
  parameter int ROWS  = 256,
  parameter int COLS  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_en_i,
  input  logic              lock_set_i,
  input  logic              pgm_req_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              pgm_done_o,
  output logic              pgm_err_o,
  output logic              rd_done_o,
  output logic              rd_err_o,
  output logic [COLS-1:0]   rd_data_o
);
  localparam logic [PAGE_W-1:0] PAGES_L = PAGE_W'(PAGES);

  fuse_addr_t      p_addr, r_addr;
  lock_ref_t       lref;
  logic [COLS-1:0] tgt_word, rd_word, lk_word, ctl_word;
  logic            refuse, set_ok, rd_deny, sticky_q;
  logic            pgm_done_q, pgm_err_q, rd_done_q, rd_err_q;
  logic [COLS-1:0] rd_data_q;

  assign p_addr = fuse_addr_t'(pgm_addr_i);
  assign r_addr = fuse_addr_t'(rd_addr_i);

  fuse_lock_map u_map (
    .row_i (p_addr.row),
    .ref_o (lref)
  );

  fuse_array #(.PAGES(PAGES), .ROWS(ROWS), .COLS(COLS)) u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (set_ok),
    .set_page_i (p_addr.page),
    .set_row_i  (p_addr.row),
    .set_col_i  (p_addr.col),
    .tgt_row_i  (p_addr.row),
    .tgt_page_i (p_addr.page),
    .tgt_word_o (tgt_word),
    .rd_page_i  (r_addr.page),
    .rd_row_i   (r_addr.row),
    .rd_word_o  (rd_word),
    .lk_row_i   (lref.lk_row),
    .lk_word_o  (lk_word),
    .ctl_word_o (ctl_word)
  );

  fuse_prog_check #(.PAGES(PAGES), .COLS(COLS)) u_chk (
    .pgm_en_i   (pgm_en_i),
    .sticky_i   (sticky_q),
    .addr_i     (p_addr),
    .lref_i     (lref),
    .tgt_word_i (tgt_word),
    .lk_word_i  (lk_word),
    .ctl_word_i (ctl_word),
    .refuse_o   (refuse)
  );

  assign set_ok  = pgm_req_i && !refuse;
  // key rows on page 0 are never readable
  assign rd_deny = (r_addr.page >= PAGES_L) ||
                   ((r_addr.page == 4'd0) && (r_addr.row >= 8'd12) && (r_addr.row <= 8'd35));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q   <= 1'b0;
      pgm_done_q <= 1'b0;
      pgm_err_q  <= 1'b0;
      rd_done_q  <= 1'b0;
      rd_err_q   <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      sticky_q   <= sticky_q || lock_set_i;
      pgm_done_q <= pgm_req_i;
      pgm_err_q  <= pgm_req_i && refuse;
      rd_done_q  <= rd_req_i;
      rd_err_q   <= rd_req_i && rd_deny;
      if (rd_req_i) rd_data_q <= rd_deny ? '0 : rd_word;
    end
  end

  assign pgm_done_o = pgm_done_q;
  assign pgm_err_o  = pgm_err_q;
  assign rd_done_o  = rd_done_q;
  assign rd_err_o   = rd_err_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/fuse_guard_chk.sv
module fuse_guard_chk #(
  parameter int COLS = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pgm_en_i,
  input logic        pgm_req_i,
  input logic [16:0] pgm_addr_i,
  input logic        rd_req_i,
  input logic [16:0] rd_addr_i,
  input logic        pgm_done_o,
  input logic        pgm_err_o,
  input logic        rd_done_o,
  input logic        rd_err_o,
  input logic [COLS-1:0] rd_data_o
);
  // R2
  pgm_done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_i |=> pgm_done_o);
  // R2
  pgm_done_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_req_i |=> !pgm_done_o);
  // R2
  rd_done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_done_o);
  // R7
  pgm_err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_err_o |-> pgm_done_o);
  // R3
  pgm_disabled_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_req_i && !pgm_en_i) |=> pgm_err_o);
  // R9
  key_row_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_addr_i[16:13] == 4'd0 && rd_addr_i[12:5] >= 8'd12 && rd_addr_i[12:5] <= 8'd35)
      |=> (rd_err_o && rd_data_o == '0));
  // R11
  rd_err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_done_o && rd_data_o == '0));
  // R8
  bad_page_pgm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_req_i && pgm_addr_i[16:13] >= 4'd3) |=> pgm_err_o);
endmodule

bind fuse_guard fuse_guard_chk #(.COLS(COLS)) u_fuse_guard_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pgm_en_i   (pgm_en_i),
  .pgm_req_i  (pgm_req_i),
  .pgm_addr_i (pgm_addr_i),
  .rd_req_i   (rd_req_i),
  .rd_addr_i  (rd_addr_i),
  .pgm_done_o (pgm_done_o),
  .pgm_err_o  (pgm_err_o),
  .rd_done_o  (rd_done_o),
  .rd_err_o   (rd_err_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/test_fuse_guard.sv
module test_fuse_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pgm_en_i = 1'b0;
  logic        lock_set_i = 1'b0;
  logic        pgm_req_i = 1'b0;
  logic [16:0] pgm_addr_i = '0;
  logic        rd_req_i = 1'b0;
  logic [16:0] rd_addr_i = '0;
  logic        pgm_done_o, pgm_err_o, rd_done_o, rd_err_o;
  logic [31:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] ref_mem [768];
  bit          ref_lock = 1'b0;

  always #10 clk_i = ~clk_i;

  fuse_guard i_fuse_guard (
    .clk_i, .rst_ni, .pgm_en_i, .lock_set_i, .pgm_req_i, .pgm_addr_i,
    .rd_req_i, .rd_addr_i, .pgm_done_o, .pgm_err_o, .rd_done_o, .rd_err_o, .rd_data_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R5 guard table: returns {hit, row, col}
  function automatic logic [13:0] guard_of(int rw);
    if (rw == 4)                return {1'b1, 8'd4, 5'd31};
    if (rw >= 8  && rw <= 11)   return {1'b1, 8'd43, 5'd27};
    if (rw >= 12 && rw <= 19)   return {1'b1, 8'd43, 5'd11};
    if (rw >= 20 && rw <= 27)   return {1'b1, 8'd43, 5'd13};
    if (rw >= 28 && rw <= 35)   return {1'b1, 8'd43, 5'd15};
    if (rw == 37)               return {1'b1, 8'd43, 5'd28};
    if (rw >= 64 && rw <= 71)   return {1'b1, 8'd43, 5'd6};
    if (rw >= 72 && rw <= 79)   return {1'b1, 8'd43, 5'd7};
    if (rw >= 80 && rw <= 87)   return {1'b1, 8'd43, 5'd8};
    return '0;
  endfunction

  function automatic bit exp_refuse(int pg, int rw, int cl);
    logic [13:0] g;
    int pos;
    if (!pgm_en_i) return 1'b1;                 // R3
    if (pg >= 3) return 1'b1;                   // R8
    if (ref_mem[pg*256+rw][cl]) return 1'b1;    // R8
    if (pg == 0) begin
      if (ref_lock && rw >= 44 && rw <= 51) return 1'b1;  // R4
      g = guard_of(rw);
      if (g[13] && ref_mem[int'(g[12:5])][g[4:0]]) return 1'b1;  // R5
    end
    if (pg == 2) begin
      pos = rw * 32 + cl;
      if (pos >= 129*32 && pos <= 255*32+27 && ref_mem[43][16]) return 1'b1;  // R6
    end
    return 1'b0;
  endfunction

  task automatic do_pgm(input int pg, input int rw, input int cl, input string req);
    bit e;
    e = exp_refuse(pg, rw, cl);
    @(negedge clk_i);
    pgm_req_i  = 1'b1;
    pgm_addr_i = {4'(pg), 8'(rw), 5'(cl)};
    @(negedge clk_i);
    pgm_req_i = 1'b0;
    chk({req, " pgm_done"}, 32'(pgm_done_o), 32'd1);
    chk({req, " pgm_err"},  32'(pgm_err_o),  32'(e));
    if (!e) ref_mem[pg*256+rw][cl] = 1'b1;
  endtask

  task automatic do_rd(input int pg, input int rw, input int junk, input string req);
    bit e;
    logic [31:0] d;
    e = (pg >= 3) || (pg == 0 && rw >= 12 && rw <= 35);
    d = e ? 32'd0 : ref_mem[pg*256+rw];
    @(negedge clk_i);
    rd_req_i  = 1'b1;
    rd_addr_i = {4'(pg), 8'(rw), 5'(junk)};
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk({req, " rd_done"}, 32'(rd_done_o), 32'd1);
    chk({req, " rd_err"},  32'(rd_err_o),  32'(e));
    chk({req, " rd_data"}, rd_data_o, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 768; i++) ref_mem[i] = (i % 256 == 0) ? 32'h0800_0002 : 32'd0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 pgm_done", 32'(pgm_done_o), 0);
    chk("R10 pgm_err",  32'(pgm_err_o), 0);
    chk("R10 rd_done",  32'(rd_done_o), 0);
    chk("R10 rd_data",  rd_data_o, 0);
    do_rd(0, 0, 0, "R10 anchor p0");
    do_rd(1, 0, 0, "R10 anchor p1");
    do_rd(2, 0, 0, "R10 anchor p2");
    do_rd(2, 200, 0, "R10 blank");
    do_pgm(1, 0, 27, "R8 anchor already set");

    // R3 disabled
    do_pgm(1, 5, 3, "R3 disabled");
    do_rd(1, 5, 0, "R3 unchanged");
    pgm_en_i = 1'b1;
    do_pgm(1, 5, 3, "R7 accepted");
    do_rd(1, 5, 0, "R7 readback");
    do_pgm(1, 5, 3, "R8 already set");
    do_pgm(3, 5, 3, "R8 bad page");
    do_rd(3, 5, 0, "R11 bad page read");
    do_rd(1, 5, 0, "R7 sticky bit");

    // R1 field positions
    do_pgm(1, 8'hA5, 31, "R1 fields");
    do_rd(1, 8'hA5, 5'h1F, "R1 col ignored");

    // R5 / R9
    do_pgm(0, 12, 0, "R5 unlocked key row");
    do_rd(0, 12, 0, "R9 key row blocked");
    do_rd(0, 35, 0, "R9 key row end");
    do_rd(0, 36, 0, "R9 row after keys");
    do_pgm(0, 43, 11, "R5 set guard 43/11");
    do_pgm(0, 13, 0, "R5 guarded row");
    do_pgm(0, 20, 0, "R5 other guard clear");
    do_pgm(0, 4, 31, "R5 row4 guard self");
    do_pgm(0, 4, 0, "R5 row4 guarded");
    do_pgm(0, 43, 8, "R5 set guard 43/8");
    do_pgm(0, 87, 2, "R5 row87 guarded");
    do_pgm(0, 88, 2, "R5 row88 free");
    do_rd(0, 43, 0, "R5 control row");

    // R6 syndrome lock
    do_pgm(2, 129, 0, "R6 range start open");
    do_pgm(0, 43, 16, "R6 set syndrome lock");
    do_pgm(2, 200, 5, "R6 inside range");
    do_pgm(2, 255, 27, "R6 range end");
    do_pgm(2, 255, 28, "R6 past range");
    do_pgm(2, 128, 31, "R6 before range");
    do_pgm(1, 200, 5, "R6 page1 free");

    // R4 sticky lock
    do_pgm(0, 44, 0, "R4 before lock");
    @(negedge clk_i); lock_set_i = 1'b1;
    @(negedge clk_i); lock_set_i = 1'b0; ref_lock = 1'b1;
    do_pgm(0, 45, 0, "R4 locked");
    do_pgm(0, 52, 0, "R4 outside range");
    repeat (5) @(negedge clk_i);
    do_pgm(0, 51, 9, "R4 persists");
    do_pgm(1, 46, 0, "R4 page1 free");

    // random mix, checked against the reference model
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 400; i++) begin
      int pg, rw, cl;
      pg = int'($urandom_range(0, 3));
      rw = ($urandom_range(0, 3) == 0) ? 43 : int'($urandom_range(0, 255));
      cl = int'($urandom_range(0, 31));
      pgm_en_i = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 1) == 0) do_pgm(pg, rw, cl, "R7 random pgm");
      else do_rd(pg, rw, cl, "R9 random read");
    end
    for (int rw = 0; rw < 256; rw += 17) do_rd(0, rw, 0, "R7 final sweep");
    summary();
  end
endmodule